// File: doc/BRIEF.md
# Addressing-Mode Bus Cycle Sequencer

This block generates the bus traffic of an 8-bit processor, one access per clock. It covers one instruction at a time across a small set of addressing modes. It fetches the opcode and operand bytes from its own program counter. It then produces the address, the read/write strobe and the write data for every cycle of the instruction, including the accesses that carry no useful data. Those are the index-add read in page zero, the wrong-page read taken before a page correction, and the unmodified write-back of a read-modify-write. An instruction's length follows from the accesses it makes; no table of cycle counts exists.

Decode is outside the block. The surrounding logic presents the operation class and addressing mode during the opcode fetch cycle, together with the two index registers and the value a store writes. A read-modify-write increments its operand. The block raises a done flag in the final cycle of each instruction. In that same cycle it raises a take-interrupt flag if the interrupt request is high, so an interrupt is only ever taken between instructions.

Top module: `mem_cycle_seq`

## Requirements
- R1: Codes: `addr_mode` 0 page zero, 1 page zero + X, 2 absolute, 3 absolute + X, 4 absolute + Y, 5 pre-indexed indirect (zp,X), 6 indirect jump; `op_class` 0 read, 1 store, 2 read-modify-write; `wr`=1 marks a write. While reset is held, and in the first cycle after it, `addr` equals RESET_PC (default 16'h0200), `wr` is 0 and `done` is 0.
- R2: In page-zero mode, a read or store takes 3 cycles: opcode at PC, operand at PC+1, then the access at {8'h00, operand}.
- R3: In page zero + X mode, the third cycle reads {8'h00, operand}. The access then goes to {8'h00, (operand+X) mod 256}, so it never leaves page zero.
- R4: In absolute mode, a read or store takes 4 cycles: PC, PC+1, PC+2, then {high, low}.
- R5: In absolute indexed reads, a 4-cycle instruction results when low+index does not carry. On a carry, a read of {high, (low+index) mod 256} comes first, and the next cycle accesses the full 16-bit sum.
- R6: Absolute indexed stores and read-modify-writes always perform the read at {high, (low+index) mod 256} before the real access, whether or not the index carries.
- R7: A read-modify-write reads the operand, writes the same value back, and then writes value+1 (mod 256), all at one address.
- R8: Pre-indexed indirect takes 6 cycles for a read or store: PC, PC+1, a read of {8'h00, operand}, pointer low at {8'h00, operand+X}, pointer high at the next page-zero byte (wrapping $FF to $00), then the data access.
- R9: An indirect jump reads the pointer low byte at {high, low} and the high byte at {high, (low+1) mod 256}. It finishes after 5 cycles, and the next opcode fetch is at the fetched address.
- R10: `done` is high only in the last cycle of an instruction. The following cycle is a read at the next opcode address (PC+2 for page-zero and indirect modes, PC+3 for absolute modes).
- R11: `take_irq` is high only in a done cycle, and only when `irq` is high in that cycle. An `irq` pulse that ends before the last cycle neither shortens the instruction nor raises `take_irq`.
- R12: `op_class` and `addr_mode` are sampled only in the opcode fetch cycle; changing them later in the instruction alters no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 2 | Operation class, sampled in the opcode fetch cycle |
| addr_mode | input | 3 | Addressing mode, sampled in the opcode fetch cycle |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| st_val | input | 8 | Value written by a store |
| rdata | input | 8 | Read data bus |
| irq | input | 1 | Interrupt request |
| addr | output | 16 | Bus address for this cycle |
| wr | output | 1 | 1 = write cycle, 0 = read cycle |
| wdata | output | 8 | Write data, valid when `wr` is 1 |
| done | output | 1 | Last cycle of the instruction |
| take_irq | output | 1 | Interrupt accepted at this boundary |

## Verification
Some properties hold on every cycle, and the assertions check those. Two consecutive writes always share one address, and the second carries the first value plus one. A done cycle is followed by a read and never by a second done. An accepted interrupt is followed by a fetch. The address traces need the bench's scenarios: the page-zero wrap of indexed and pointer accesses, the wrong-page read on a carry, the forced correction cycle for stores, the same-page pointer wrap of the indirect jump, and an `irq` pulse that ends mid-instruction. The bench compares each of these cycle by cycle against an expected list.

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq #(
  parameter logic [15:0] RESET_PC = 16'h0200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  op_class,
  input  logic [2:0]  addr_mode,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic [7:0]  st_val,
  input  logic [7:0]  rdata,
  input  logic        irq,
  output logic [15:0] addr,
  output logic        wr,
  output logic [7:0]  wdata,
  output logic        done,
  output logic        take_irq
);
  localparam logic [1:0] C_RD = 2'd0, C_ST = 2'd1, C_RMW = 2'd2;
  localparam logic [2:0] M_ZP = 3'd0, M_ZPX = 3'd1, M_ABS = 3'd2, M_ABSX = 3'd3,
                         M_ABSY = 3'd4, M_INDX = 3'd5, M_JIND = 3'd6;

  typedef enum logic [3:0] {
    S_OP, S_OPL, S_OPH, S_IDX, S_PLO, S_PHI, S_FIX, S_DATA, S_WB, S_WN
  } st_t;

  st_t         st;
  logic [15:0] pc, ea;
  logic [1:0]  cls;
  logic [2:0]  mode;
  logic [7:0]  bl, dat;
  logic        cy;

  wire [7:0]  idx    = (mode == M_ABSY) ? idx_y : idx_x;
  wire [8:0]  sum    = {1'b0, bl} + {1'b0, idx};
  wire        three  = (mode == M_ABS) || (mode == M_ABSX) || (mode == M_ABSY);
  wire [15:0] pc_nxt = pc + (three ? 16'd3 : 16'd2);

  always_comb begin
    case (st)
      S_OP:    addr = pc;
      S_OPL:   addr = pc + 16'd1;
      S_OPH:   addr = pc + 16'd2;
      S_IDX:   addr = {8'h00, bl};
      default: addr = ea;
    endcase
  end

  assign wr       = (st == S_DATA && cls == C_ST) || st == S_WB || st == S_WN;
  assign wdata    = (st == S_WN) ? dat + 8'd1 : (st == S_WB) ? dat : st_val;
  assign done     = (st == S_DATA && cls != C_RMW) || st == S_WN ||
                    (st == S_PHI && mode == M_JIND);
  assign take_irq = done & irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_OP;
      pc   <= RESET_PC;
      ea   <= '0;
      cls  <= C_RD;
      mode <= M_ZP;
      bl   <= '0;
      dat  <= '0;
      cy   <= 1'b0;
    end else begin
      case (st)
        S_OP: begin
          cls  <= op_class;
          mode <= addr_mode;
          st   <= S_OPL;
        end
        S_OPL: begin
          bl <= rdata;
          ea <= {8'h00, rdata};
          case (mode)
            M_ZPX, M_INDX:                 st <= S_IDX;
            M_ABS, M_ABSX, M_ABSY, M_JIND: st <= S_OPH;
            default:                       st <= S_DATA;
          endcase
        end
        S_OPH: begin
          if (mode == M_ABSX || mode == M_ABSY) begin
            ea <= {rdata, sum[7:0]};
            cy <= sum[8];
            st <= (cls == C_RD && !sum[8]) ? S_DATA : S_FIX;
          end else begin
            ea <= {rdata, bl};
            st <= (mode == M_JIND) ? S_PLO : S_DATA;
          end
        end
        S_IDX: begin
          ea <= {8'h00, bl + idx_x};
          st <= (mode == M_INDX) ? S_PLO : S_DATA;
        end
        S_PLO: begin
          dat      <= rdata;
          ea[7:0]  <= ea[7:0] + 8'd1;
          st       <= S_PHI;
        end
        S_PHI: begin
          if (mode == M_JIND) begin
            pc <= {rdata, dat};
            st <= S_OP;
          end else begin
            ea <= {rdata, dat};
            st <= S_DATA;
          end
        end
        S_FIX: begin
          ea[15:8] <= ea[15:8] + {7'b0, cy};
          st       <= S_DATA;
        end
        S_DATA: begin
          if (cls == C_RMW) begin
            dat <= rdata;
            st  <= S_WB;
          end else begin
            pc <= pc_nxt;
            st <= S_OP;
          end
        end
        S_WB: st <= S_WN;
        S_WN: begin
          pc <= pc_nxt;
          st <= S_OP;
        end
        default: st <= S_OP;
      endcase
    end
  end
endmodule

// File: rtl/mem_cycle_seq_chk.sv
module mem_cycle_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        wr,
  input logic [7:0]  wdata,
  input logic        done,
  input logic        take_irq
);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fetch_is_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wr);

  p_rmw_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && $past(wr)) |-> addr == $past(addr));

  p_rmw_increment_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && $past(wr)) |-> wdata == $past(wdata) + 8'd1);

  p_irq_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq && !wr);
endmodule

bind mem_cycle_seq mem_cycle_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata),
  .done(done), .take_irq(take_irq)
);

// File: tb/mem_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module mem_cycle_seq_tb_top;
  localparam logic [1:0] C_RD = 2'd0, C_ST = 2'd1, C_RMW = 2'd2;
  localparam logic [2:0] M_ZP = 3'd0, M_ZPX = 3'd1, M_ABS = 3'd2, M_ABSX = 3'd3,
                         M_ABSY = 3'd4, M_INDX = 3'd5, M_JIND = 3'd6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  op_class = C_RD;
  logic [2:0]  addr_mode = M_ZP;
  logic [7:0]  idx_x = 8'h00, idx_y = 8'h00, st_val = 8'h00;
  logic        irq = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic        wr, done, take_irq;
  logic [7:0]  wdata;

  logic [7:0]  mem [0:4095];
  logic [15:0] a_q[$];
  logic        w_q[$], d_q[$], t_q[$];
  logic [7:0]  v_q[$];
  string       g_q[$];
  int          checks = 0, errors = 0;
  logic [15:0] pc_m = 16'h0200;
  bit          fin = 1'b0;

  always #2.5 clk = ~clk;

  mem_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .addr_mode(addr_mode),
    .idx_x(idx_x), .idx_y(idx_y), .st_val(st_val), .rdata(rdata), .irq(irq),
    .addr(addr), .wr(wr), .wdata(wdata), .done(done), .take_irq(take_irq)
  );

  assign rdata = mem[addr[11:0]];
  always @(posedge clk) if (rst_n && wr) mem[addr[11:0]] <= wdata;

  function automatic logic [7:0] peek(input logic [15:0] a);
    return mem[a[11:0]];
  endfunction

  task automatic poke(input logic [15:0] a, input logic [7:0] v);
    mem[a[11:0]] = v;
  endtask

  task automatic push(input logic [15:0] a, input logic w, input logic [7:0] v,
                      input logic last, input logic ti, input string tg);
    a_q.push_back(a); w_q.push_back(w); v_q.push_back(v);
    d_q.push_back(last); t_q.push_back(last & ti); g_q.push_back(tg);
  endtask

  always @(negedge clk) begin
    if (rst_n && a_q.size() != 0) begin
      logic [15:0] ea; logic ew, ed, et; logic [7:0] ev; string tg;
      ea = a_q.pop_front(); ew = w_q.pop_front(); ev = v_q.pop_front();
      ed = d_q.pop_front(); et = t_q.pop_front(); tg = g_q.pop_front();
      checks++;
      if (addr !== ea || wr !== ew || done !== ed || take_irq !== et || (ew && wdata !== ev)) begin
        errors++;
        $display("FAIL %s: addr=%h wr=%b wdata=%h done=%b take_irq=%b expected addr=%h wr=%b wdata=%h done=%b take_irq=%b",
                 tg, addr, wr, wdata, done, take_irq, ea, ew, ev, ed, et);
      end
    end
  end

  task automatic instr(input string tg, input logic [1:0] c, input logic [2:0] m,
                       input logic [7:0] o, input logic [7:0] oh, input logic [7:0] x,
                       input logic [7:0] y, input logic [7:0] sv, input int irqm, input bit scr);
    logic [15:0] ea, np;
    logic [8:0]  s;
    logic [7:0]  lo, hi, v, idx, p8;
    logic        ti, three, dn;
    int          n;
    ti    = (irqm == 1);
    three = (m == M_ABS) || (m == M_ABSX) || (m == M_ABSY);
    poke(pc_m, 8'hEA);
    poke(pc_m + 16'd1, o);
    if (three || m == M_JIND) poke(pc_m + 16'd2, oh);
    op_class = c; addr_mode = m; idx_x = x; idx_y = y; st_val = sv; irq = ti;
    push(pc_m, 1'b0, 8'h00, 1'b0, ti, tg);
    push(pc_m + 16'd1, 1'b0, 8'h00, 1'b0, ti, tg);
    ea = {8'h00, o};
    np = pc_m + (three ? 16'd3 : 16'd2);
    case (m)
      M_ZPX: begin
        push({8'h00, o}, 1'b0, 8'h00, 1'b0, ti, tg);
        p8 = o + x;
        ea = {8'h00, p8};
      end
      M_ABS: begin
        push(pc_m + 16'd2, 1'b0, 8'h00, 1'b0, ti, tg);
        ea = {oh, o};
      end
      M_ABSX, M_ABSY: begin
        push(pc_m + 16'd2, 1'b0, 8'h00, 1'b0, ti, tg);
        idx = (m == M_ABSY) ? y : x;
        s   = {1'b0, o} + {1'b0, idx};
        ea  = {oh, o} + {8'h00, idx};
        if (c != C_RD || s[8]) push({oh, s[7:0]}, 1'b0, 8'h00, 1'b0, ti, tg);
      end
      M_INDX: begin
        push({8'h00, o}, 1'b0, 8'h00, 1'b0, ti, tg);
        p8 = o + x;
        push({8'h00, p8}, 1'b0, 8'h00, 1'b0, ti, tg);
        lo = peek({8'h00, p8});
        p8 = p8 + 8'd1;
        push({8'h00, p8}, 1'b0, 8'h00, 1'b0, ti, tg);
        hi = peek({8'h00, p8});
        ea = {hi, lo};
      end
      M_JIND: begin
        push(pc_m + 16'd2, 1'b0, 8'h00, 1'b0, ti, tg);
        push({oh, o}, 1'b0, 8'h00, 1'b0, ti, tg);
        lo = peek({oh, o});
        p8 = o + 8'd1;
        push({oh, p8}, 1'b0, 8'h00, 1'b1, ti, tg);
        hi = peek({oh, p8});
        np = {hi, lo};
      end
      default: ;
    endcase
    if (m != M_JIND) begin
      if (c == C_ST) push(ea, 1'b1, sv, 1'b1, ti, tg);
      else if (c == C_RMW) begin
        v = peek(ea);
        push(ea, 1'b0, 8'h00, 1'b0, ti, tg);
        push(ea, 1'b1, v, 1'b0, ti, tg);
        push(ea, 1'b1, v + 8'd1, 1'b1, ti, tg);
      end else push(ea, 1'b0, 8'h00, 1'b1, ti, tg);
    end
    n = 0;
    do begin
      @(negedge clk);
      n++;
      dn = done;
      #1;
      if (scr && n == 2) begin addr_mode = ~m; op_class = ~c; end
      if (irqm == 2) irq = (n == 2);
    end while (!dn && n < 20);
    pc_m = np;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if (addr !== 16'h0200 || wr !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: addr=%h wr=%b done=%b expected addr=0200 wr=0 done=0", addr, wr, done);
    end
    poke(16'h0010, 8'h5A);
    poke(16'h0345, 8'h11);
    poke(16'h0601, 8'hFF);
    poke(16'h0020, 8'h7F);
    poke(16'h0045, 8'h34); poke(16'h0046, 8'h07);
    poke(16'h00FF, 8'h50); poke(16'h0000, 8'h07);
    poke(16'h01FF, 8'h00); poke(16'h0100, 8'h04);
    @(posedge clk);
    #1 rst_n = 1'b1;
    instr("R1 R2 zp read",            C_RD,  M_ZP,   8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0);
    instr("R2 zp store",              C_ST,  M_ZP,   8'h11, 8'h00, 8'h00, 8'h00, 8'hC3, 0, 0);
    instr("R3 zp+X wrap",             C_RD,  M_ZPX,  8'hF0, 8'h00, 8'h20, 8'h00, 8'h00, 0, 0);
    instr("R4 R11 abs read irq held", C_RD,  M_ABS,  8'h45, 8'h03, 8'h00, 8'h00, 8'h00, 1, 0);
    instr("R5 abs+X no carry",        C_RD,  M_ABSX, 8'h30, 8'h05, 8'h05, 8'h00, 8'h00, 0, 0);
    instr("R5 abs+X carry",           C_RD,  M_ABSX, 8'hF0, 8'h05, 8'h20, 8'h00, 8'h00, 0, 0);
    instr("R5 abs+Y carry",           C_RD,  M_ABSY, 8'hFF, 8'h06, 8'h00, 8'h01, 8'h00, 0, 0);
    instr("R6 abs+X store no carry",  C_ST,  M_ABSX, 8'h30, 8'h05, 8'h02, 8'h00, 8'h9D, 0, 0);
    instr("R6 R7 abs+X rmw carry",    C_RMW, M_ABSX, 8'hFF, 8'h05, 8'h02, 8'h00, 8'h00, 0, 0);
    instr("R7 R11 zp rmw irq pulse",  C_RMW, M_ZP,   8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 2, 0);
    instr("R8 (zp,X) read",           C_RD,  M_INDX, 8'h40, 8'h00, 8'h05, 8'h00, 8'h00, 0, 0);
    instr("R8 R12 (zp,X) wrap store", C_ST,  M_INDX, 8'hF0, 8'h00, 8'h0F, 8'h00, 8'hA7, 0, 1);
    instr("R9 indirect jump $01FF",   C_RD,  M_JIND, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 0, 0);
    instr("R10 fetch at jump target", C_RD,  M_ZP,   8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0);
    @(posedge clk);
    checks++;
    if (a_q.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d expected cycles left unseen, expected 0", a_q.size());
    end
    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule